// File: doc/BRIEF.md
# IDE PIO Timing Compiler

This block turns the PIO timing needs of the two drives on one IDE channel into the three bytes that a timing controller loads. The two drives are a primary unit (drive 0) and a secondary unit (drive 1). For each unit, software or a sequencer gives a present flag and three durations in nanoseconds: address setup, active strobe pulse and total cycle. It also gives the bus clock frequency in MHz and a read-prefetch enable. The block rounds each duration up to whole bus clocks and limits each count to the range the timing hardware can hold. It then packs one cycle byte per drive and one shared byte. The shared byte carries the address setup that both drives must use, the strobe-ready delay and the prefetch enable.

A request starts with a one-cycle `start` pulse. All inputs are latched in that cycle. The six clock counts are computed one after another on a single bit-serial restoring divider. When the three output bytes are updated, `done` pulses for one cycle. The outputs then keep their values until the next request finishes.

Top module: `pio_timing_compiler`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `cycle_pri`, `cycle_sec` and `shared_cfg` are all 0x00.
- R2: Each duration T (ns) becomes the clock count floor((T × bus_mhz + 999) / 1000), which is T rounded up to whole bus clocks.
- R3: The address-setup count of a present drive is limited to the range 1 to 4 clocks.
- R4: The strobe count of a present drive is limited to 1 to 16 clocks and is placed in bits [7:4] of that drive's cycle byte as (count − 1).
- R5: The recovery time in ns is the cycle time minus setup minus strobe. It is taken as 0 when that difference is negative. Its count is limited to 2 to 17 clocks and placed in bits [3:0] of the cycle byte as (count − 2).
- R6: A drive whose present flag is 0 uses address 1, strobe 1 and recovery 2 clocks, so its cycle byte is 0x00.
- R7: The shared address setup is the larger of the two drives' limited address counts. It is placed in `shared_cfg` bits [5:4] as (count − 1).
- R8: `shared_cfg` bit 6 equals the latched prefetch enable. Bits [2:1] hold (DRDY_CLKS − 2), which is 0 by default. Bits 7, 3 and 0 are 0.
- R9: A `start` pulse while `busy` is 1 is ignored: the result and the number of `done` pulses match the first request alone.
- R10: `done` is high for exactly one cycle per accepted request, with `busy` low in that cycle. The output bytes change only in a cycle in which `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request pulse; inputs latched when idle |
| bus_mhz | input | MHZ_W | Bus clock frequency in MHz |
| pri_present | input | 1 | Drive 0 is fitted |
| pri_setup_ns | input | TIME_W | Drive 0 address setup time |
| pri_strobe_ns | input | TIME_W | Drive 0 active strobe time |
| pri_cycle_ns | input | TIME_W | Drive 0 total cycle time |
| sec_present | input | 1 | Drive 1 is fitted |
| sec_setup_ns | input | TIME_W | Drive 1 address setup time |
| sec_strobe_ns | input | TIME_W | Drive 1 active strobe time |
| sec_cycle_ns | input | TIME_W | Drive 1 total cycle time |
| prefetch_en | input | 1 | Read prefetch enable for the shared byte |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle pulse when the bytes are updated |
| cycle_pri | output | 8 | Drive 0 cycle byte |
| cycle_sec | output | 8 | Drive 1 cycle byte |
| shared_cfg | output | 8 | Shared address, strobe-ready and prefetch byte |

## Verification
The assertions assume that `start` is only a pulse and that nothing outside the block needs the timing inputs to stay stable after the request cycle, because the block latches them when it accepts a request. They also assume `DRDY_CLKS` is between 2 and 5, so that its field fits in two bits. The stimulus respects these rules: it raises `start` only on a falling edge and only for one cycle. It issues a new request only once `busy` is low, except in the one test that deliberately pulses `start` during a running request with different inputs.

// File: rtl/pio_tc_pkg.sv
// Package: shared widths, hardware limits, the sequencer state type and the
// count limiter used by the PIO timing compiler.
package pio_tc_pkg;

    localparam int CNT_W    = 5;   // width of a saturated clock count
    localparam int ADDR_MIN = 1;
    localparam int ADDR_MAX = 4;
    localparam int DATA_MIN = 1;
    localparam int DATA_MAX = 16;
    localparam int REC_MIN  = 2;
    localparam int REC_MAX  = 17;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_PACK
    } ptc_state_e;

    // Limit a clock count to [lo, hi].
    function automatic logic [CNT_W-1:0] limit_cnt(input logic [CNT_W-1:0] v,
                                                   input int lo, input int hi);
        if (int'(v) < lo)      return CNT_W'(lo);
        else if (int'(v) > hi) return CNT_W'(hi);
        else                   return v;
    endfunction

endpackage

// File: rtl/ptc_ceil_div.sv
// Module: ptc_ceil_div
// Computes ceil(time_ns * mhz / DIVISOR) as (time_ns*mhz + DIVISOR-1)/DIVISOR
// with a restoring divider that retires one quotient bit per cycle.
// Assumes: go is a single-cycle pulse that arrives only while the divider is idle.
// The result is valid from the cycle in which ready pulses until the next go.
// It saturates to all ones of CNT_W.
module ptc_ceil_div
    import pio_tc_pkg::*;
#(
    parameter int TIME_W  = 16,
    parameter int MHZ_W   = 8,
    parameter int DIVISOR = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [TIME_W-1:0] time_ns,
    input  logic [MHZ_W-1:0]  mhz,
    output logic              ready,
    output logic [CNT_W-1:0]  clocks
);

    localparam int PROD_W = TIME_W + MHZ_W + 1;
    localparam int REM_W  = $clog2(DIVISOR);
    localparam int ITER_W = $clog2(PROD_W + 1);

    logic [PROD_W-1:0] quo;
    logic [REM_W-1:0]  rem;
    logic [ITER_W-1:0] iter;
    logic              running;
    logic [REM_W:0]    trial;
    logic              take;

    // Trial subtraction for the next quotient bit.
    always_comb begin
        trial = {rem, quo[PROD_W-1]};
        take  = (trial >= (REM_W+1)'(DIVISOR));
    end

    // Load the rounded dividend, then shift in one quotient bit per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quo     <= '0;
            rem     <= '0;
            iter    <= '0;
            running <= 1'b0;
            ready   <= 1'b0;
        end else begin
            ready <= 1'b0;
            if (go) begin
                quo     <= PROD_W'(time_ns) * PROD_W'(mhz) + PROD_W'(DIVISOR - 1);
                rem     <= '0;
                iter    <= ITER_W'(PROD_W);
                running <= 1'b1;
            end else if (running) begin
                rem  <= take ? REM_W'(trial - (REM_W+1)'(DIVISOR)) : trial[REM_W-1:0];
                quo  <= {quo[PROD_W-2:0], take};
                iter <= iter - 1'b1;
                if (iter == ITER_W'(1)) begin
                    running <= 1'b0;
                    ready   <= 1'b1;
                end
            end
        end
    end

    // Saturate the quotient to the count width.
    always_comb begin
        clocks = (|quo[PROD_W-1:CNT_W]) ? {CNT_W{1'b1}} : quo[CNT_W-1:0];
    end

    AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (rem < REM_W'(DIVISOR)));                                  // R2
    AST_READY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);                                                     // R10

endmodule

// File: rtl/ptc_drive_pack.sv
// Module: ptc_drive_pack
// Limits one drive's three raw clock counts and packs its cycle byte.
// An absent drive is forced to the minimum counts.
// Assumes: raw counts are already saturated to CNT_W bits.
module ptc_drive_pack
    import pio_tc_pkg::*;
(
    input  logic             present,
    input  logic [CNT_W-1:0] addr_raw,
    input  logic [CNT_W-1:0] data_raw,
    input  logic [CNT_W-1:0] rec_raw,
    output logic [CNT_W-1:0] addr_eff,
    output logic [7:0]       cycle_byte
);

    logic [CNT_W-1:0] data_eff;
    logic [CNT_W-1:0] rec_eff;
    logic [CNT_W-1:0] data_fld;
    logic [CNT_W-1:0] rec_fld;

    // Choose limited counts, or the minima when the drive is absent.
    always_comb begin
        if (present) begin
            addr_eff = limit_cnt(addr_raw, ADDR_MIN, ADDR_MAX);
            data_eff = limit_cnt(data_raw, DATA_MIN, DATA_MAX);
            rec_eff  = limit_cnt(rec_raw,  REC_MIN,  REC_MAX);
        end else begin
            addr_eff = CNT_W'(ADDR_MIN);
            data_eff = CNT_W'(DATA_MIN);
            rec_eff  = CNT_W'(REC_MIN);
        end
        data_fld   = data_eff - CNT_W'(DATA_MIN);
        rec_fld    = rec_eff  - CNT_W'(REC_MIN);
        cycle_byte = {data_fld[3:0], rec_fld[3:0]};
    end

endmodule

// File: rtl/pio_timing_compiler.sv
// Module: pio_timing_compiler
// Converts the PIO timing of two drives into two cycle bytes and one shared
// byte. It latches the inputs on start and runs six roundings on one
// sequential divider. It then packs the bytes and pulses done.
// Assumes: start is a pulse; a start while busy is dropped; 2 <= DRDY_CLKS <= 5.
module pio_timing_compiler
    import pio_tc_pkg::*;
#(
    parameter int TIME_W    = 16,
    parameter int MHZ_W     = 8,
    parameter int DRDY_CLKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [MHZ_W-1:0]  bus_mhz,
    input  logic              pri_present,
    input  logic [TIME_W-1:0] pri_setup_ns,
    input  logic [TIME_W-1:0] pri_strobe_ns,
    input  logic [TIME_W-1:0] pri_cycle_ns,
    input  logic              sec_present,
    input  logic [TIME_W-1:0] sec_setup_ns,
    input  logic [TIME_W-1:0] sec_strobe_ns,
    input  logic [TIME_W-1:0] sec_cycle_ns,
    input  logic              prefetch_en,
    output logic              busy,
    output logic              done,
    output logic [7:0]        cycle_pri,
    output logic [7:0]        cycle_sec,
    output logic [7:0]        shared_cfg
);

    localparam int NDRV  = 2;
    localparam int NKIND = 3;
    localparam int NVAL  = NDRV * NKIND;
    localparam int IDX_W = $clog2(NVAL);
    localparam logic [1:0] DRDY_FLD = 2'(DRDY_CLKS - 2);

    ptc_state_e        state;
    logic [IDX_W-1:0]  idx;
    logic [MHZ_W-1:0]  lat_mhz;
    logic              lat_pf;
    logic              lat_present [NDRV];
    logic [TIME_W-1:0] lat_setup   [NDRV];
    logic [TIME_W-1:0] lat_strobe  [NDRV];
    logic [TIME_W-1:0] lat_cycle   [NDRV];
    logic              in_present  [NDRV];
    logic [TIME_W-1:0] in_setup    [NDRV];
    logic [TIME_W-1:0] in_strobe   [NDRV];
    logic [TIME_W-1:0] in_cycle    [NDRV];
    logic [TIME_W-1:0] rec_ns      [NDRV];
    logic [CNT_W-1:0]  raw         [NVAL];
    logic [CNT_W-1:0]  addr_eff    [NDRV];
    logic [7:0]        cyc_byte    [NDRV];
    logic              div_go;
    logic              div_ready;
    logic [CNT_W-1:0]  div_clocks;
    logic [TIME_W-1:0] operand;
    logic [CNT_W-1:0]  ax;
    logic [CNT_W-1:0]  ax_fld;

    // Gather the port inputs into per-drive arrays.
    always_comb begin
        in_present[0] = pri_present;   in_present[1] = sec_present;
        in_setup[0]   = pri_setup_ns;  in_setup[1]   = sec_setup_ns;
        in_strobe[0]  = pri_strobe_ns; in_strobe[1]  = sec_strobe_ns;
        in_cycle[0]   = pri_cycle_ns;  in_cycle[1]   = sec_cycle_ns;
    end

    // Per-drive recovery time and byte packing.
    for (genvar d = 0; d < NDRV; d++) begin : g_drv
        logic [TIME_W:0] used_ns;

        // Recovery is cycle minus setup minus strobe, floored at zero.
        always_comb begin
            used_ns   = {1'b0, lat_setup[d]} + {1'b0, lat_strobe[d]};
            rec_ns[d] = ({1'b0, lat_cycle[d]} > used_ns)
                      ? TIME_W'({1'b0, lat_cycle[d]} - used_ns) : '0;
        end

        ptc_drive_pack u_pack (
            .present    (lat_present[d]),
            .addr_raw   (raw[d*NKIND + 0]),
            .data_raw   (raw[d*NKIND + 1]),
            .rec_raw    (raw[d*NKIND + 2]),
            .addr_eff   (addr_eff[d]),
            .cycle_byte (cyc_byte[d])
        );
    end

    // Select the duration that the divider converts next.
    always_comb begin
        logic             drv;
        logic [IDX_W-1:0] kind;
        drv  = (idx >= IDX_W'(NKIND));
        kind = drv ? idx - IDX_W'(NKIND) : idx;
        case (kind)
            IDX_W'(0): operand = lat_setup[drv];
            IDX_W'(1): operand = lat_strobe[drv];
            default:   operand = rec_ns[drv];
        endcase
        div_go = (state == ST_ISSUE);
    end

    ptc_ceil_div #(
        .TIME_W  (TIME_W),
        .MHZ_W   (MHZ_W),
        .DIVISOR (1000)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (div_go),
        .time_ns (operand),
        .mhz     (lat_mhz),
        .ready   (div_ready),
        .clocks  (div_clocks)
    );

    // The shared address setup is the larger of the two drives' counts.
    always_comb begin
        ax     = (addr_eff[0] > addr_eff[1]) ? addr_eff[0] : addr_eff[1];
        ax_fld = ax - CNT_W'(ADDR_MIN);
    end

    // Sequencer: latch inputs, convert six durations, then pack the outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            idx        <= '0;
            busy       <= 1'b0;
            done       <= 1'b0;
            cycle_pri  <= 8'h00;
            cycle_sec  <= 8'h00;
            shared_cfg <= 8'h00;
            lat_mhz    <= '0;
            lat_pf     <= 1'b0;
            for (int d = 0; d < NDRV; d++) begin
                lat_present[d] <= 1'b0;
                lat_setup[d]   <= '0;
                lat_strobe[d]  <= '0;
                lat_cycle[d]   <= '0;
            end
            for (int v = 0; v < NVAL; v++) raw[v] <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        lat_mhz <= bus_mhz;
                        lat_pf  <= prefetch_en;
                        for (int d = 0; d < NDRV; d++) begin
                            lat_present[d] <= in_present[d];
                            lat_setup[d]   <= in_setup[d];
                            lat_strobe[d]  <= in_strobe[d];
                            lat_cycle[d]   <= in_cycle[d];
                        end
                        idx   <= '0;
                        busy  <= 1'b1;
                        state <= ST_ISSUE;
                    end
                end
                ST_ISSUE: state <= ST_WAIT;
                ST_WAIT: begin
                    if (div_ready) begin
                        raw[idx] <= div_clocks;
                        if (idx == IDX_W'(NVAL - 1)) begin
                            state <= ST_PACK;
                        end else begin
                            idx   <= idx + 1'b1;
                            state <= ST_ISSUE;
                        end
                    end
                end
                default: begin
                    cycle_pri  <= cyc_byte[0];
                    cycle_sec  <= cyc_byte[1];
                    shared_cfg <= {1'b0, lat_pf, ax_fld[1:0], 1'b0, DRDY_FLD, 1'b0};
                    done       <= 1'b1;
                    busy       <= 1'b0;
                    state      <= ST_IDLE;
                end
            endcase
        end
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                       // R10
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);                                                       // R10
    AST_OUTPUTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(cycle_pri) && $stable(cycle_sec) && $stable(shared_cfg))); // R10
    AST_START_ACCEPTED: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);                                            // R9
    AST_LATCH_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(lat_mhz) && $stable(lat_pf) && $stable(lat_cycle[0])));  // R9
    AST_ABSENT_MINIMUM: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !lat_present[1]) |-> (cycle_sec == 8'h00));                   // R6
    AST_SHARED_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!shared_cfg[7] && !shared_cfg[3] && !shared_cfg[0]));        // R8

endmodule

// File: tb/test_pio_timing_compiler.sv
// Scoreboard bench: the driver task queues expected bytes, the monitor
// compares them on every done pulse.
module test_pio_timing_compiler;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  bus_mhz = '0;
    logic        pri_present = 1'b0, sec_present = 1'b0, prefetch_en = 1'b0;
    logic [15:0] pri_setup_ns = '0, pri_strobe_ns = '0, pri_cycle_ns = '0;
    logic [15:0] sec_setup_ns = '0, sec_strobe_ns = '0, sec_cycle_ns = '0;
    logic        busy, done;
    logic [7:0]  cycle_pri, cycle_sec, shared_cfg;

    int errors = 0;
    int checks = 0;
    int extra_done = 0;
    logic prev_done = 1'b0;
    logic [23:0] exp_q [$];

    always #10 clk = ~clk;

    pio_timing_compiler i_pio_timing_compiler (
        .clk(clk), .rst_n(rst_n), .start(start), .bus_mhz(bus_mhz),
        .pri_present(pri_present), .pri_setup_ns(pri_setup_ns),
        .pri_strobe_ns(pri_strobe_ns), .pri_cycle_ns(pri_cycle_ns),
        .sec_present(sec_present), .sec_setup_ns(sec_setup_ns),
        .sec_strobe_ns(sec_strobe_ns), .sec_cycle_ns(sec_cycle_ns),
        .prefetch_en(prefetch_en), .busy(busy), .done(done),
        .cycle_pri(cycle_pri), .cycle_sec(cycle_sec), .shared_cfg(shared_cfg)
    );

    // R2 rounding rule
    function automatic int to_clk(int t, int m);
        return (t * m + 999) / 1000;
    endfunction

    function automatic int lim(int v, int lo, int hi);
        return (v < lo) ? lo : ((v > hi) ? hi : v);
    endfunction

    // Expected address count and cycle byte for one drive (R3..R6).
    function automatic int drv_addr(bit p, int s, int m);
        return p ? lim(to_clk(s, m), 1, 4) : 1;
    endfunction

    function automatic logic [7:0] drv_byte(bit p, int s, int a, int c, int m);
        int r, dc, rc;
        if (!p) return 8'h00;
        r  = c - s - a;
        if (r < 0) r = 0;
        dc = lim(to_clk(a, m), 1, 16);
        rc = lim(to_clk(r, m), 2, 17);
        return {4'(dc - 1), 4'(rc - 2)};
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // Driver: wait for idle, apply a request, queue its expected bytes.
    task automatic send(int m, bit pf,
                        bit pp, int ps, int pa, int pc,
                        bit sp, int ss, int sa, int sc);
        int ax;
        logic [23:0] e;
        @(negedge clk);
        while (busy) @(negedge clk);
        bus_mhz = 8'(m); prefetch_en = pf;
        pri_present = pp; pri_setup_ns = 16'(ps); pri_strobe_ns = 16'(pa); pri_cycle_ns = 16'(pc);
        sec_present = sp; sec_setup_ns = 16'(ss); sec_strobe_ns = 16'(sa); sec_cycle_ns = 16'(sc);
        ax = drv_addr(pp, ps, m);
        if (drv_addr(sp, ss, m) > ax) ax = drv_addr(sp, ss, m);
        e[23:16] = drv_byte(pp, ps, pa, pc, m);
        e[15:8]  = drv_byte(sp, ss, sa, sc, m);
        e[7:0]   = {1'b0, pf, 2'(ax - 1), 4'b0000};   // R7 R8
        exp_q.push_back(e);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    // Monitor: compare each result, and check the pulse width and busy.
    always @(negedge clk) begin
        if (rst_n) begin
            if (done) begin
                checks++;
                if (busy) begin
                    errors++;
                    $display("FAIL R10 busy actual=1 expected=0 at done");
                end
                if (prev_done) begin
                    errors++;
                    $display("FAIL R10 done width actual=2+ expected=1");
                end
                if (exp_q.size() == 0) begin
                    extra_done++;
                end else begin
                    logic [23:0] e;
                    e = exp_q.pop_front();
                    check("R4/R5 cycle_pri", cycle_pri, e[23:16]);
                    check("R6 cycle_sec", cycle_sec, e[15:8]);
                    check("R7/R8 shared_cfg", shared_cfg, e[7:0]);
                end
            end
            prev_done = done;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 done", {7'b0, done}, 8'h00);
        check("R1 busy", {7'b0, busy}, 8'h00);
        check("R1 cycle_pri", cycle_pri, 8'h00);
        check("R1 cycle_sec", cycle_sec, 8'h00);
        check("R1 shared_cfg", shared_cfg, 8'h00);
        rst_n = 1'b1;

        // R2 typical slow timing at 33 MHz, both drives
        send(33, 1, 1, 70, 165, 600, 1, 30, 80, 383);
        // R2 the 40 MHz 80 ns case rounds to 4 clocks
        send(40, 0, 1, 25, 80, 240, 1, 25, 80, 240);
        // R3 R4 R5 low limits: tiny times
        send(50, 1, 1, 0, 10, 20, 1, 0, 0, 0);
        // R3 R4 R5 high limits
        send(100, 0, 1, 200, 500, 2000, 1, 90, 170, 900);
        // R5 negative recovery saturates to 2 clocks
        send(66, 1, 1, 30, 40, 50, 1, 100, 200, 100);
        // R6 absent secondary, absent primary, both absent
        send(33, 0, 1, 120, 290, 700, 0, 999, 999, 9999);
        send(33, 1, 0, 999, 999, 9999, 1, 120, 290, 700);
        send(80, 0, 0, 500, 500, 5000, 0, 500, 500, 5000);
        // R7 shared address from the secondary drive
        send(50, 0, 1, 10, 100, 300, 1, 70, 100, 300);
        // R2 saturation at full-scale inputs
        send(255, 1, 1, 65535, 65535, 65535, 1, 1, 1, 65535);
        drain();

        // R9 start while busy is ignored
        send(33, 0, 1, 70, 165, 600, 1, 70, 165, 600);
        repeat (20) @(negedge clk);
        bus_mhz = 8'd100; prefetch_en = 1'b1;
        pri_setup_ns = 16'd500; pri_strobe_ns = 16'd500; pri_cycle_ns = 16'd3000;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        drain();
        repeat (400) @(negedge clk);
        checks++;
        if (extra_done != 0) begin
            errors++;
            $display("FAIL R9 extra done pulses actual=%0d expected=0", extra_done);
        end
        // R10 outputs hold after done
        check("R10 hold cycle_pri", cycle_pri, drv_byte(1, 70, 165, 600, 33));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule